// File: doc/BRIEF.md
# Serial Port Modem Handshake Control and Status

This block is the modem-line corner of a 16550-style serial port. It holds a modem control register whose request-to-send and data-terminal-ready bits drive two active-low handshake outputs. It also samples the four active-low modem inputs (clear-to-send, data-set-ready, ring, carrier detect) into a modem status register. That register reports the present state of each line, and a sticky change flag per line records an inactive-going transition. A modem-status interrupt is raised from those flags when an interrupt-enable bit allows it.

The CPU side is a plain register port. Three select strobes pick the control, status or enable register, and `wr_en`/`rd_en` qualify a write or a side-effecting read. `rdata` is combinational from the selected register, so it can be observed without `rd_en`. Only a status read with `rd_en` high clears the change flags. No data stream passes through the block, so there is no valid/ready interface, and every pin is a plain level. Loop mode turns the control bits back into the status bits for self-test and holds both handshake outputs inactive.

Top module: `uart_modem_ctl`

## Requirements
- R1: Outside loop mode, `rts_n` is the complement of control bit 1 and `dtr_n` is the complement of control bit 0. Both take their new value in the cycle after the write edge.
- R2: After reset, `rts_n` and `dtr_n` are high, `irq_modem` is low, the control and enable registers read zero, and the status change flags (status bits 3:0) read zero.
- R3: While control bit 4 (loop) is set, `rts_n` and `dtr_n` are both held high, whatever control bits 1 and 0 hold.
- R4: Outside loop mode, status bits 4, 5, 6 and 7 read as the complements of `cts_n`, `dsr_n`, `ri_n` and `dcd_n`. Each input passes two synchronising flops, so a pin change is visible in the status after the second rising clock edge.
- R5: Status bits 0, 1, 2 and 3 (for cts, dsr, ri, dcd) are each set when the matching active-low line goes from low to high. They stay set until a status read. A high-to-low change sets nothing.
- R6: A status read with `rd_en` returns the present value and clears bits 3:0 at that clock edge. A low-to-high change detected at the same edge still leaves its flag set.
- R7: In loop mode the status lines come from control bits instead of the pins: cts from bit 1, dsr from bit 0, ri from bit 2, dcd from bit 3. Pin changes are then ignored.
- R8: `irq_modem` is high exactly when enable bit 3 is set and at least one change flag is set. It goes low after a status read that clears the flags.
- R9: Control reads back bits 4:0 with bits 7:5 zero, and enable reads back bits 3:0 with bits 7:4 zero. With no select active, `rdata` is zero.
- R10: Changes on `cts_n` have no effect on `rts_n` or `dtr_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_mcr | input | 1 | Selects the modem control register |
| sel_msr | input | 1 | Selects the modem status register |
| sel_ier | input | 1 | Selects the interrupt enable register |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe; with sel_msr it clears the change flags |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data from the selected register |
| cts_n | input | 1 | Clear-to-send line, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready line, active low, asynchronous |
| ri_n | input | 1 | Ring indicator line, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect line, active low, asynchronous |
| rts_n | output | 1 | Request-to-send output, active low |
| dtr_n | output | 1 | Data-terminal-ready output, active low |
| irq_modem | output | 1 | Modem-status interrupt request |

## Verification
A corrupted previous-sample register shows up as a spurious or missing change flag on the next status read, three edges after the pin moves. A wrong status mux shows at once in `rdata` bits 7:4 while the status register is selected. A lost flag at the clearing edge, or a flag that is never cleared, shows on the very next status read and on `irq_modem` one cycle after that read. Faults in the loop forcing appear on `rts_n`/`dtr_n` in the cycle after the control write.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned LINES   = 4;
  // control register fields
  localparam int unsigned C_DTR   = 0;
  localparam int unsigned C_RTS   = 1;
  localparam int unsigned C_OUT1  = 2;
  localparam int unsigned C_OUT2  = 3;
  localparam int unsigned C_LOOP  = 4;
  localparam int unsigned CTRL_W  = 5;
  localparam int unsigned IEN_W   = 4;
  localparam int unsigned IEN_MS  = 3;
  // line order inside a line vector: {dcd, ri, dsr, cts}
  typedef logic [LINES-1:0] line_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 4,
  parameter logic [W-1:0] INIT  = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= INIT;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_n,
  input  logic         clr,
  output logic [W-1:0] delta,
  output logic         rise_any
);
  logic [W-1:0] prev_n;
  logic [W-1:0] rise;

  assign rise     = lvl_n & ~prev_n;
  assign rise_any = |rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_n <= '1;
      delta  <= '0;
    end else begin
      prev_n <= lvl_n;
      delta  <= (clr ? '0 : delta) | rise;
    end
  end

  // R5: flags are sticky while no clearing read happens
  assert_delta_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((delta & $past(delta)) == $past(delta)));

  // R6: a detected edge survives a clearing read at the same edge
  assert_rise_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_any |=> ((delta & $past(rise)) == $past(rise)));
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import modem_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_mcr,
  input  logic             sel_msr,
  input  logic             sel_ier,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             cts_n,
  input  logic             dsr_n,
  input  logic             ri_n,
  input  logic             dcd_n,
  output logic             rts_n,
  output logic             dtr_n,
  output logic             irq_modem
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [IEN_W-1:0]  ien_q;
  line_t pins_n, sync_n, loop_n, lvl_n, delta;
  logic  rise_any;
  logic  wr_ctrl, wr_ien, rd_stat;
  logic [REG_W-1:0] stat;

  assign wr_ctrl = sel_mcr & wr_en;
  assign wr_ien  = sel_ier & wr_en;
  assign rd_stat = sel_msr & rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
      if (wr_ien)  ien_q  <= wdata[IEN_W-1:0];
    end
  end

  assign pins_n = {dcd_n, ri_n, dsr_n, cts_n};

  mdm_sync #(.STAGES(SYNC_STAGES), .W(LINES), .INIT('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_n), .q(sync_n));

  assign loop_n = ~{ctrl_q[C_OUT2], ctrl_q[C_OUT1], ctrl_q[C_DTR], ctrl_q[C_RTS]};
  assign lvl_n  = ctrl_q[C_LOOP] ? loop_n : sync_n;

  mdm_delta #(.W(LINES)) u_delta (
    .clk(clk), .rst_n(rst_n), .lvl_n(lvl_n), .clr(rd_stat),
    .delta(delta), .rise_any(rise_any));

  assign stat = {~lvl_n, delta};

  always_comb begin
    rdata = '0;
    if (sel_mcr)      rdata[CTRL_W-1:0] = ctrl_q;
    else if (sel_ier) rdata[IEN_W-1:0]  = ien_q;
    else if (sel_msr) rdata             = stat;
  end

  assign rts_n     = ~(ctrl_q[C_RTS] & ~ctrl_q[C_LOOP]);
  assign dtr_n     = ~(ctrl_q[C_DTR] & ~ctrl_q[C_LOOP]);
  assign irq_modem = ien_q[IEN_MS] & (|delta);

  // R1: outputs follow a control write outside loop mode
  assert_rts_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wdata[C_LOOP]) |=> (rts_n == !$past(wdata[C_RTS]) && dtr_n == !$past(wdata[C_DTR])));

  // R3: loop write forces both handshake outputs inactive
  assert_loop_inactive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[C_LOOP]) |=> (rts_n && dtr_n));

  // R8: a clearing read with no new edge drops the interrupt
  assert_irq_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !rise_any) |=> !irq_modem);
endmodule

// File: tb/tb_uart_modem_ctl.sv
module tb_uart_modem_ctl;
  logic clk = 0, rst_n = 0;
  logic sel_mcr = 0, sel_msr = 0, sel_ier = 0, wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, rdata;
  logic cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
  logic rts_n, dtr_n, irq_modem;
  int total = 0, fails = 0;
  logic [7:0] m_ctrl = 0, m_ien = 0;
  logic [3:0] m_delta = 0;

  always #4 clk = ~clk;

  uart_modem_ctl dut (.*);

  function automatic logic [3:0] lvl_of(logic [7:0] c, logic [3:0] p);
    return c[4] ? ~{c[3], c[2], c[0], c[1]} : p;
  endfunction
  function automatic logic [3:0] pins();
    return {dcd_n, ri_n, dsr_n, cts_n};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int which, logic [7:0] d);
    @(negedge clk);
    sel_mcr = (which == 0); sel_ier = (which == 1); wr_en = 1; wdata = d;
    @(negedge clk);
    sel_mcr = 0; sel_ier = 0; wr_en = 0;
  endtask

  task automatic rd_msr(output logic [7:0] v);
    @(negedge clk);
    sel_msr = 1; rd_en = 1; #1 v = rdata;
    @(negedge clk);
    sel_msr = 0; rd_en = 0;
  endtask

  task automatic check_outs(string tag);
    logic loop;
    loop = m_ctrl[4];
    chk({tag, " R1/R3 rts_n"}, rts_n, !(m_ctrl[1] && !loop));
    chk({tag, " R1/R3 dtr_n"}, dtr_n, !(m_ctrl[0] && !loop));
    chk({tag, " R8 irq"}, irq_modem, m_ien[3] && (m_delta != 0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 rts_n", rts_n, 1); chk("R2 dtr_n", dtr_n, 1); chk("R2 irq", irq_modem, 0);
    rst_n = 1;
    @(negedge clk);
    sel_mcr = 1; #1 chk("R2 ctrl zero", rdata, 0); sel_mcr = 0;
    sel_ier = 1; #1 chk("R2 ien zero", rdata, 0); sel_ier = 0;
    sel_msr = 1; #1 chk("R2 status zero", rdata, 0); sel_msr = 0;
    #1 chk("R9 no select", rdata, 0);

    // R4 latency: two edges to status
    @(negedge clk); cts_n = 0;
    @(posedge clk); @(negedge clk); sel_msr = 1; #1 chk("R4 after one edge", rdata[4], 0);
    @(posedge clk); @(negedge clk); #1 chk("R4 after two edges", rdata[4], 1);
    sel_msr = 0;
    repeat (3) @(negedge clk);
    rd_msr(v); chk("R5 falling sets nothing", v, 8'h10);

    // R5 rising edge, R6 kept at the clearing edge
    @(negedge clk); cts_n = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); sel_msr = 1; rd_en = 1; #1 chk("R6 read returns old flag", rdata[0], 0);
    @(negedge clk); rd_en = 0; #1 chk("R6 edge kept over clear", rdata[0], 1);
    sel_msr = 0;
    rd_msr(v); chk("R5 flag reported", v, 8'h01);
    rd_msr(v); chk("R6 flag cleared", v, 8'h00);

    // R9 readback widths
    wr(0, 8'hEF); sel_mcr = 1; #1 chk("R9 ctrl readback", rdata, 8'h0F); sel_mcr = 0;
    wr(1, 8'hFA); sel_ier = 1; #1 chk("R9 ien readback", rdata, 8'h0A); sel_ier = 0;
    m_ctrl = 8'h0F; m_ien = 8'h0A;
    // R10: cts_n toggles leave outputs alone
    @(negedge clk); cts_n = 0; repeat (4) @(negedge clk);
    chk("R10 rts_n held", rts_n, 0); chk("R10 dtr_n held", dtr_n, 0);
    cts_n = 1; repeat (4) @(negedge clk);
    m_delta = 4'b0001;
    check_outs("R10");
    rd_msr(v); m_delta = 0;

    // random phase
    for (int it = 0; it < 400; it++) begin
      int act;
      logic [3:0] lo, ln;
      act = $urandom_range(0, 3);
      lo = lvl_of(m_ctrl, pins());
      case (act)
        0: begin
          @(negedge clk);
          {dcd_n, ri_n, dsr_n, cts_n} = 4'($urandom);
          repeat (4) @(negedge clk);
        end
        1: begin
          m_ctrl = {3'b0, 5'($urandom)};
          wr(0, 8'($urandom) & 8'hE0 | m_ctrl);
          repeat (3) @(negedge clk);
        end
        2: begin
          m_ien = {4'b0, 4'($urandom)};
          wr(1, m_ien);
        end
        default: begin
          rd_msr(v);
          chk(m_ctrl[4] ? "R7 status in loop" : "R4/R5 status", v, {~lo, m_delta});
          m_delta = 0;
          #1 chk("R8 irq after read", irq_modem, 0);
        end
      endcase
      ln = lvl_of(m_ctrl, pins());
      m_delta |= ln & ~lo;
      check_outs("rand");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule